// File: doc/BRIEF.md
# Instruction-Count-Triggered Prefetch Replay List

This block stores a short trace of memory addresses. Each address is paired with the retired-instruction count at which it was touched. The trace is written while a future event is pre-executed speculatively; that pre-execution begins when the normal context stalls on a last-level cache miss. When the same event later runs for real, the block plays the trace back as prefetch requests. It does not guess strides or next lines. Each stored entry is offered to the prefetch engine once the live instruction count comes within a fixed lookahead distance of the count recorded for it. The lookahead distance is a parameter with a default of 100.

Two independent list sets are held, so up to two future events can be recorded ahead. A record port appends to the set chosen by `rec_set_i`. Replay draws from the set chosen by `play_set_i` and is gated by `play_en_i`. Each set has its own clear input, used at the start of each event, and its own sticky overflow flag. Entries leave in first-in first-out order, and the head only advances on a valid/ready handshake. One instance serves instruction addresses and a second instance serves data addresses. Both sit beside the prefetch engine.

Storage is a single synchronous-read memory holding `NSETS*DEPTH` entries. `DEPTH` must be a power of two and at least 2.

Top module: `icount_replay_prefetch`

## Requirements
- R1: A cycle with `rec_valid_i` high appends the pair (`rec_addr_i`, `rec_cnt_i`) to the tail of set `rec_set_i`. Replay presents the entries of a set in the order they were recorded, with the address on `pf_addr_o`.
- R2: `pf_valid_o` is high in a cycle exactly when three conditions hold. First, the selected set has a head entry. Second, `play_en_i` was high at the previous edge. Third, the value of `icount_i` sampled at the previous edge plus LOOKAHEAD is strictly greater than the head's recorded count, in unsigned arithmetic. When the sum equals the recorded count, no request is made.
- R3: The head entry is removed only at an edge where `pf_valid_o` and `pf_ready_i` are both high. While a request waits for `pf_ready_i`, `pf_addr_o` holds the same address.
- R4: A record into a set that already holds DEPTH entries (after any removal at the same edge) is dropped. That set's bit of `overflow_o` is then set and stays set until the set is cleared.
- R5: `clr_i[s]` empties set s and clears `overflow_o[s]` at the next edge. It takes priority over a record into, or a removal from, set s at the same edge.
- R6: The sets are independent. Recording into, clearing, or overflowing one set leaves the content and flag of the other unchanged. `play_set_i` selects which set is replayed.
- R7: While `play_en_i` is low, no request is raised from the next cycle on, and no entry is consumed.
- R8: While `rst` is high, the next cycle shows `pf_valid_o` low and `overflow_o` all zero, and every set is empty.
- R9: An entry recorded at edge k can raise a request in the cycle after edge k+1 at the earliest. When a request is accepted, the next entry of the same set is presented in the following cycle, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | NSETS | Per-set clear, pulsed at the start of an event |
| rec_valid_i | input | 1 | Record strobe |
| rec_set_i | input | SET_W | Set that receives the record |
| rec_addr_i | input | ADDR_W | Address to record |
| rec_cnt_i | input | CNT_W | Instruction count of the recorded access |
| play_en_i | input | 1 | Replay enable |
| play_set_i | input | SET_W | Set being replayed |
| icount_i | input | CNT_W | Live retired-instruction count |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_ready_i | input | 1 | Prefetch engine accepts the request |
| pf_addr_o | output | ADDR_W | Prefetch address |
| overflow_o | output | NSETS | Per-set sticky overflow flag |

## Verification
Several properties are checked on every cycle. The reset state is checked, and so is the stickiness of each overflow flag. An overflow flag may only rise right after a record into its own set, and a clear always drops it. Disabling replay must silence the request one cycle later. A request stalled on `pf_ready_i` must keep its address. The bench's scenarios are the only way to show the rest: the replay order, the exact edge at which the lookahead comparison fires including the equal-count boundary, the number of entries kept after a fill past DEPTH, clear priority over a same-cycle record, and isolation between the two sets. A behavioural queue model tracks these cycle by cycle.

// File: rtl/replay_pkg.sv
package replay_pkg;
  // bits needed to index 'n' items, at least one
  function automatic int sel_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/replay_ram.sv
module replay_ram #(
  parameter int AW = 5,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 2 ** AW;

  logic [DW-1:0] mem [WORDS];

  // one write port, one registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/replay_set_ctl.sv
module replay_set_ctl #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push_req,
  input  logic             pop,
  output logic             push_ok,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx_nxt,
  output logic [PTR_W-1:0] fill_nxt,
  output logic             ovf
);
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [PTR_W-1:0] rd_nxt, wr_base;
  logic             full;

  // clear wins; removal is taken before the room check
  always_comb begin
    rd_nxt   = clr ? '0 : rd_q + PTR_W'(pop);
    wr_base  = clr ? '0 : wr_q;
    fill_nxt = wr_base - rd_nxt;
    full     = (fill_nxt == PTR_W'(DEPTH));
    push_ok  = push_req && !clr && !full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= '0;
      ovf  <= 1'b0;
    end else begin
      rd_q <= rd_nxt;
      wr_q <= wr_base + PTR_W'(push_ok);
      ovf  <= clr ? 1'b0 : (ovf | (push_req && full));
    end
  end

  assign wr_idx     = wr_q[IDX_W-1:0];
  assign rd_idx_nxt = rd_nxt[IDX_W-1:0];
endmodule

// File: rtl/replay_trigger.sv
module replay_trigger #(
  parameter int CNT_W     = 32,
  parameter int LOOKAHEAD = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] icnt_i,
  input  logic             avail_i,
  input  logic [CNT_W-1:0] head_cnt_i,
  output logic             fire_o
);
  localparam int SUM_W = CNT_W + 1;

  logic             en_q;
  logic [CNT_W-1:0] icnt_q;
  logic [SUM_W-1:0] reach;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      icnt_q <= '0;
    end else begin
      en_q   <= en_i;
      icnt_q <= icnt_i;
    end
  end

  // one extra bit keeps the sum from wrapping
  always_comb begin
    reach  = {1'b0, icnt_q} + SUM_W'(LOOKAHEAD);
    fire_o = avail_i && en_q && (reach > {1'b0, head_cnt_i});
  end
endmodule

// File: rtl/icount_replay_prefetch.sv
module icount_replay_prefetch
  import replay_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  parameter int DEPTH     = 16,
  parameter int LOOKAHEAD = 100,
  parameter int NSETS     = 2,
  parameter int SET_W     = sel_bits(NSETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSETS-1:0]  clr_i,
  input  logic              rec_valid_i,
  input  logic [SET_W-1:0]  rec_set_i,
  input  logic [ADDR_W-1:0] rec_addr_i,
  input  logic [CNT_W-1:0]  rec_cnt_i,
  input  logic              play_en_i,
  input  logic [SET_W-1:0]  play_set_i,
  input  logic [CNT_W-1:0]  icount_i,
  output logic              pf_valid_o,
  input  logic              pf_ready_i,
  output logic [ADDR_W-1:0] pf_addr_o,
  output logic [NSETS-1:0]  overflow_o
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int PTR_W  = IDX_W + 1;
  localparam int RAM_AW = SET_W + IDX_W;
  localparam int ENT_W  = ADDR_W + CNT_W;

  logic [NSETS-1:0]  push_req, push_ok, pop_s;
  logic [IDX_W-1:0]  wr_idx     [NSETS];
  logic [IDX_W-1:0]  rd_idx_nxt [NSETS];
  logic [PTR_W-1:0]  fill_nxt   [NSETS];
  logic              pop;
  logic              avail_q;
  logic [SET_W-1:0]  set_q;
  logic [ENT_W-1:0]  head;
  logic [CNT_W-1:0]  head_cnt;

  assign pop = pf_valid_o && pf_ready_i;

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    assign push_req[s] = rec_valid_i && (rec_set_i == SET_W'(s));
    assign pop_s[s]    = pop && (set_q == SET_W'(s));

    replay_set_ctl #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W)
    ) u_ctl (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr_i[s]),
      .push_req  (push_req[s]),
      .pop       (pop_s[s]),
      .push_ok   (push_ok[s]),
      .wr_idx    (wr_idx[s]),
      .rd_idx_nxt(rd_idx_nxt[s]),
      .fill_nxt  (fill_nxt[s]),
      .ovf       (overflow_o[s])
    );
  end

  // read address follows the post-removal head, so a new head shows next cycle
  replay_ram #(.AW(RAM_AW), .DW(ENT_W)) u_ram (
    .clk  (clk),
    .we   (|push_ok),
    .waddr({rec_set_i, wr_idx[rec_set_i]}),
    .wdata({rec_addr_i, rec_cnt_i}),
    .raddr({play_set_i, rd_idx_nxt[play_set_i]}),
    .rdata(head)
  );

  // head is valid if the set held an entry before this edge's record
  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= 1'b0;
      set_q   <= '0;
    end else begin
      avail_q <= (fill_nxt[play_set_i] != '0);
      set_q   <= play_set_i;
    end
  end

  assign head_cnt  = head[CNT_W-1:0];
  assign pf_addr_o = head[ENT_W-1 -: ADDR_W];

  replay_trigger #(.CNT_W(CNT_W), .LOOKAHEAD(LOOKAHEAD)) u_trig (
    .clk       (clk),
    .rst       (rst),
    .en_i      (play_en_i),
    .icnt_i    (icount_i),
    .avail_i   (avail_q),
    .head_cnt_i(head_cnt),
    .fire_o    (pf_valid_o)
  );
endmodule

// File: rtl/replay_list_chk.sv
module replay_list_chk #(
  parameter int ADDR_W = 32,
  parameter int NSETS  = 2,
  parameter int SET_W  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [NSETS-1:0]  clr_i,
  input logic              rec_valid_i,
  input logic [SET_W-1:0]  rec_set_i,
  input logic              play_en_i,
  input logic [SET_W-1:0]  play_set_i,
  input logic              pf_valid_o,
  input logic              pf_ready_i,
  input logic [ADDR_W-1:0] pf_addr_o,
  input logic [NSETS-1:0]  overflow_o
);
  logic             armed;
  logic [SET_W-1:0] prev_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      prev_set <= '0;
    end else begin
      armed    <= 1'b1;
      prev_set <= play_set_i;
    end
  end

  // R8
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!pf_valid_o && overflow_o == '0));

  // R7
  replay_off_chk: assert property (@(posedge clk) disable iff (rst)
    !play_en_i |=> !pf_valid_o);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && pf_valid_o && !pf_ready_i && clr_i == '0 && play_set_i == prev_set)
    |=> (pf_addr_o == $past(pf_addr_o)));

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (overflow_o[s] && !clr_i[s]) |=> overflow_o[s]);

    // R4
    ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(overflow_o[s]) |-> ($past(rec_valid_i) && $past(rec_set_i) == SET_W'(s)));

    // R5
    clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
      clr_i[s] |=> !overflow_o[s]);
  end
endmodule

bind icount_replay_prefetch replay_list_chk #(
  .ADDR_W(ADDR_W), .NSETS(NSETS), .SET_W(SET_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_i      (clr_i),
  .rec_valid_i(rec_valid_i),
  .rec_set_i  (rec_set_i),
  .play_en_i  (play_en_i),
  .play_set_i (play_set_i),
  .pf_valid_o (pf_valid_o),
  .pf_ready_i (pf_ready_i),
  .pf_addr_o  (pf_addr_o),
  .overflow_o (overflow_o)
);

// File: tb/icount_replay_prefetch_test.sv
module icount_replay_prefetch_test;
  localparam int DEPTH = 16;
  localparam int LA    = 100;
  localparam int NS    = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  clr = '0;
  logic        rec_v = 1'b0;
  logic        rec_s = 1'b0;
  logic [31:0] rec_a = '0, rec_c = '0;
  logic        pen = 1'b0;
  logic        pset = 1'b0;
  logic [31:0] icnt = '0;
  logic        rdy = 1'b0;
  logic        pv_o;
  logic [31:0] pa_o;
  logic [1:0]  ovf_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  icount_replay_prefetch uut (
    .clk(clk), .rst(rst), .clr_i(clr), .rec_valid_i(rec_v), .rec_set_i(rec_s),
    .rec_addr_i(rec_a), .rec_cnt_i(rec_c), .play_en_i(pen), .play_set_i(pset),
    .icount_i(icnt), .pf_valid_o(pv_o), .pf_ready_i(rdy), .pf_addr_o(pa_o),
    .overflow_o(ovf_o)
  );

  // behavioural model: one queue of {addr,cnt} per set
  logic [63:0] mq [NS][$];
  logic [1:0]  m_ovf = '0;
  logic        m_en = 1'b0, m_avail = 1'b0;
  logic [31:0] m_icnt = '0;
  logic [63:0] m_hd = '0;
  int          m_set = 0;
  logic [31:0] got [$];

  function automatic logic m_pv();
    return m_avail && m_en && ({32'b0, m_icnt} + 64'(LA) > {32'b0, m_hd[31:0]});
  endfunction

  always @(posedge clk) begin : model
    logic pop;
    if (rst) begin
      for (int s = 0; s < NS; s++) mq[s].delete();
      m_ovf = '0; m_en = 1'b0; m_avail = 1'b0; m_icnt = '0; m_set = 0;
    end else begin
      pop = m_pv() && rdy;
      for (int s = 0; s < NS; s++)
        if (clr[s]) begin mq[s].delete(); m_ovf[s] = 1'b0; end
      if (pop && !clr[m_set]) void'(mq[m_set].pop_front());
      m_avail = (mq[pset].size() != 0);
      if (m_avail) m_hd = mq[pset][0];
      if (rec_v && !clr[rec_s]) begin
        if (mq[rec_s].size() < DEPTH) mq[rec_s].push_back({rec_a, rec_c});
        else m_ovf[rec_s] = 1'b1;
      end
      m_en = pen; m_icnt = icnt; m_set = int'(pset);
    end
  end

  task automatic ck(input logic ok, input string msg);
    total++;
    if (!ok) begin bad++; $display("FAIL %s", msg); end
  endtask

  // inputs are set at a negedge before calling; compare at the next negedge
  task automatic tick();
    if (pv_o && rdy) got.push_back(pa_o);
    @(negedge clk);
    ck(pv_o == m_pv(), $sformatf("R2 valid act=%0b exp=%0b", pv_o, m_pv()));
    if (m_pv()) ck(pa_o == m_hd[63:32], $sformatf("R1 addr act=%h exp=%h", pa_o, m_hd[63:32]));
    ck(ovf_o == m_ovf, $sformatf("R4 overflow act=%b exp=%b", ovf_o, m_ovf));
  endtask

  task automatic rec(input logic s, input logic [31:0] a, input logic [31:0] c);
    rec_v = 1'b1; rec_s = s; rec_a = a; rec_c = c;
    tick();
    rec_v = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clear(input logic [1:0] m);
    clr = m; tick(); clr = '0;
  endtask

  initial begin : watchdog
    #2000000;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    ck(pv_o == 1'b0 && ovf_o == 2'b00, $sformatf("R8 reset act=%b/%b exp=0/00", pv_o, ovf_o));
    idle(2);

    // R1: ordered replay while the count ramps
    for (int i = 0; i < 5; i++) rec(1'b0, 32'h1000 + 32'(i * 4), 32'(200 + 100 * i));
    got.delete(); pen = 1'b1; pset = 1'b0; rdy = 1'b1;
    for (int i = 0; i < 80; i++) begin icnt = 32'(i * 10); tick(); end
    ck(got.size() == 5, $sformatf("R1 count act=%0d exp=5", got.size()));
    for (int i = 0; i < 5 && i < got.size(); i++)
      ck(got[i] == 32'h1000 + 32'(i * 4), $sformatf("R1 order act=%h exp=%h", got[i], 32'h1000 + 32'(i * 4)));

    // R2: equal sum must not fire, one more must
    clear(2'b01); got.delete(); icnt = 32'd50;
    rec(1'b0, 32'h2000, 32'd150);
    idle(5);
    ck(pv_o == 1'b0, $sformatf("R2 equal boundary act=%0b exp=0", pv_o));
    icnt = 32'd51; tick();
    ck(pv_o == 1'b1 && pa_o == 32'h2000, $sformatf("R2 fire act=%0b/%h exp=1/2000", pv_o, pa_o));
    idle(3);

    // R3 and R9: stall holds the head, then back-to-back drain
    rdy = 1'b0; got.delete();
    rec(1'b0, 32'h2100, 32'd10); rec(1'b0, 32'h2104, 32'd20); rec(1'b0, 32'h2108, 32'd30);
    idle(4);
    ck(pv_o == 1'b1 && pa_o == 32'h2100, $sformatf("R3 hold act=%0b/%h exp=1/2100", pv_o, pa_o));
    rdy = 1'b1; idle(3);
    ck(got.size() == 3, $sformatf("R9 drain act=%0d exp=3", got.size()));
    idle(2);

    // R4 and R6: overflow of set 1 only
    pen = 1'b0; clear(2'b10); got.delete();
    for (int i = 0; i <= DEPTH; i++) rec(1'b1, 32'h3000 + 32'(i), 32'd0);
    tick();
    ck(ovf_o == 2'b10, $sformatf("R4 flag act=%b exp=10", ovf_o));
    pen = 1'b1; pset = 1'b1; icnt = 32'd1000; idle(25);
    ck(got.size() == DEPTH, $sformatf("R4 kept act=%0d exp=%0d", got.size(), DEPTH));
    if (got.size() == DEPTH)
      ck(got[DEPTH-1] == 32'h300f, $sformatf("R4 last act=%h exp=300f", got[DEPTH-1]));
    ck(ovf_o[1] == 1'b1, $sformatf("R4 sticky act=%b exp=1", ovf_o[1]));

    // R5: clear beats a same-cycle record
    pen = 1'b0; got.delete();
    rec(1'b1, 32'h3100, 32'd0); rec(1'b1, 32'h3104, 32'd0);
    clr = 2'b10; rec(1'b1, 32'h3108, 32'd0); clr = '0;
    pen = 1'b1; idle(6);
    ck(got.size() == 0, $sformatf("R5 empty act=%0d exp=0", got.size()));
    ck(ovf_o[1] == 1'b0, $sformatf("R5 flag act=%b exp=0", ovf_o[1]));

    // R6: each set replays only its own entries
    pen = 1'b0; clear(2'b11); got.delete();
    for (int i = 0; i < 3; i++) rec(1'b0, 32'h4000 + 32'(i), 32'd5);
    for (int i = 0; i < 2; i++) rec(1'b1, 32'h5000 + 32'(i), 32'd5);
    pen = 1'b1; pset = 1'b1; idle(5);
    ck(got.size() == 2 && got[0] == 32'h5000, $sformatf("R6 set1 act=%0d exp=2", got.size()));
    got.delete(); pset = 1'b0; idle(6);
    ck(got.size() == 3 && got[0] == 32'h4000, $sformatf("R6 set0 act=%0d exp=3", got.size()));

    // R7: disabled replay consumes nothing
    pen = 1'b0; clear(2'b01); got.delete();
    rec(1'b0, 32'h6000, 32'd0); rec(1'b0, 32'h6004, 32'd0);
    idle(6);
    ck(got.size() == 0 && pv_o == 1'b0, $sformatf("R7 idle act=%0d/%0b exp=0/0", got.size(), pv_o));
    pen = 1'b1; idle(5);
    ck(got.size() == 2, $sformatf("R7 kept act=%0d exp=2", got.size()));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule